// File: doc/BRIEF.md
# USB Full/Low Speed Tracking Controller

This block sits in the receive path of a passive USB bus monitor that listens on a mixed-speed segment. It picks the speed the bit decoder should use: full speed by default, or low speed while a preamble-gated low-speed transaction is on the wire. It reads the PID stream coming out of the decoder and the packet-end strobes, and it follows each transaction as it is expected to unfold. When the transaction completes it hands the decoder back to full speed. It also does so when an expected low-speed packet does not arrive within its time window, and when a PID arrives that the transaction does not allow.

A separate wait limit applies while the device is expected to answer an IN token. A shorter one applies to all the other low-speed waits. Both limits are counted in low-speed bit times, from a tick supplied by clock recovery. A strap input marks a segment that carries only low-speed traffic. On such a segment no preamble is ever sent, so the strap holds the decoder at low speed with no tracking at all. The speed select is also driven out on a second port as a detect flag.

Top module: `usb_speed_tracker`

## Requirements
- R1: While reset is asserted and the strap is low, `ls_sel` is 0. `ls_detect` always carries the same value as `ls_sel`.
- R2: At full speed, a preamble PID (4'hC) with `pid_valid` set makes `ls_sel` 1 from the next cycle. At full speed, no other input raises `ls_sel`.
- R3: In the first low-speed window, a SETUP (4'hD) or OUT (4'h1) token keeps low speed until the next `pkt_end`. `ls_sel` is 0 from the cycle after that strobe.
- R4: After a SETUP or OUT token has ended, a second preamble opens a data window. In that window, one DATA0 (4'h3), DATA1 (4'hB), ACK (4'h2), NAK (4'hA) or STALL (4'hE) keeps low speed until its `pkt_end`. Full speed returns on the cycle after that strobe.
- R5: In the first low-speed window, an IN token (4'h9) opens a response window. A DATA0 or DATA1 in that window keeps low speed until its `pkt_end`. Full speed returns on the cycle after that strobe.
- R6: In the IN response window, 18 `ls_tick` pulses with no PID and no `pkt_end` return full speed on the cycle after the 18th pulse. 17 such pulses leave low speed in place.
- R7: In the other two low-speed waiting windows (first window and data window), 17 quiet `ls_tick` pulses return full speed on the cycle after the 17th pulse. 16 such pulses leave low speed in place.
- R8: Every `pid_valid` and every `pkt_end` restarts the tick count. Ticks are not counted at full speed. Ticks are not counted while a packet accepted at low speed is still in flight, so a long low-speed DATA packet does not time out.
- R9: At low speed, a PID that the current window does not expect returns full speed on the next cycle. This includes any PID that arrives before the accepted packet has ended.
- R10: While `ls_only` is 1, `ls_sel` is 1 in the same cycle and all PIDs, ends and ticks are ignored. When `ls_only` falls, the tracker is at full speed and waits for a fresh first preamble.
- R11: While waiting for the second preamble, any PID other than a preamble cancels the transaction. A later preamble then opens a first window again, not a data window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-path clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pid_valid | input | 1 | One-cycle strobe: `pid` holds a decoded PID |
| pid | input | 4 | Decoded 4-bit PID value |
| pkt_end | input | 1 | One-cycle strobe at the end of a packet |
| ls_tick | input | 1 | One-cycle pulse per low-speed bit time |
| ls_only | input | 1 | Strap: the segment carries low-speed traffic only |
| ls_sel | output | 1 | 1 selects low-speed decoding, 0 selects full speed |
| ls_detect | output | 1 | Copy of `ls_sel` exported as a detect flag |

## Verification
The tracker's state shows at the ports only through `ls_sel`. A wrong transition therefore shows either as a speed flip one cycle after the PID or `pkt_end` that caused it, or as a missing flip at that cycle. If the tracker has lost its place in the sequence (for example, it treats the data window as a first window), this shows only when the next PID is accepted or rejected. That is why the bench drives sequences that differ only in what came earlier. A timer that is off by one shows on the exact tick the window should close, so each limit is probed at the limit and one tick before it. A cycle-accurate behavioural model is compared with both outputs on every clock, so any divergence is reported within one cycle.

// File: rtl/usb_spd_pkg.sv
package usb_spd_pkg;

  localparam int PID_W = 4;

  localparam logic [PID_W-1:0] PID_OUT   = 4'h1;
  localparam logic [PID_W-1:0] PID_IN    = 4'h9;
  localparam logic [PID_W-1:0] PID_SETUP = 4'hD;
  localparam logic [PID_W-1:0] PID_DATA0 = 4'h3;
  localparam logic [PID_W-1:0] PID_DATA1 = 4'hB;
  localparam logic [PID_W-1:0] PID_ACK   = 4'h2;
  localparam logic [PID_W-1:0] PID_NAK   = 4'hA;
  localparam logic [PID_W-1:0] PID_STALL = 4'hE;
  localparam logic [PID_W-1:0] PID_PRE   = 4'hC;

  // Role of a PID within a preamble-gated transaction
  typedef enum logic [2:0] {
    PC_NONE,
    PC_PRE,
    PC_TOK_SO,   // SETUP or OUT token
    PC_TOK_IN,
    PC_DATA,
    PC_HSK,
    PC_OTHER
  } pid_cls_e;

  typedef enum logic [2:0] {
    ST_FS_IDLE,      // full speed, waiting for a first preamble
    ST_LS_TOKEN,     // low speed, waiting for the token
    ST_LS_TOK_END,   // low speed, SETUP/OUT token in flight
    ST_FS_DATA_PRE,  // full speed, waiting for the second preamble
    ST_LS_DATA,      // low speed, waiting for one data or handshake
    ST_LS_DATA_END,  // low speed, that packet in flight
    ST_LS_IN_WAIT,   // low speed, waiting for the device's data
    ST_LS_IN_END     // low speed, the device's data in flight
  } spd_state_e;

endpackage

// File: rtl/usb_spd_pid_class.sv
module usb_spd_pid_class
  import usb_spd_pkg::*;
(
  input  logic             pid_valid,
  input  logic [PID_W-1:0] pid,
  output pid_cls_e         cls
);

  always_comb begin
    cls = PC_NONE;
    if (pid_valid) begin
      unique case (pid)
        PID_PRE:                      cls = PC_PRE;
        PID_SETUP, PID_OUT:           cls = PC_TOK_SO;
        PID_IN:                       cls = PC_TOK_IN;
        PID_DATA0, PID_DATA1:         cls = PC_DATA;
        PID_ACK, PID_NAK, PID_STALL:  cls = PC_HSK;
        default:                      cls = PC_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/usb_spd_timer.sv
module usb_spd_timer #(
  parameter int GEN_LIMIT = 17,
  parameter int IN_LIMIT  = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic in_win,
  input  logic tick,
  output logic expire
);

  localparam int MAX_LIM = (GEN_LIMIT > IN_LIMIT) ? GEN_LIMIT : IN_LIMIT;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic [CNT_W-1:0] lim;
  logic [CNT_W:0]   cnt_inc;

  generate
    if (GEN_LIMIT == IN_LIMIT) begin : g_one_limit
      assign lim = CNT_W'(GEN_LIMIT);
    end else begin : g_two_limits
      assign lim = in_win ? CNT_W'(IN_LIMIT) : CNT_W'(GEN_LIMIT);
    end
  endgenerate

  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign expire  = run && !clr && tick && (cnt_inc >= {1'b0, lim});

  always_comb begin
    cnt_en = clr || !run || tick;
    cnt_d  = cnt_q;
    if (clr || !run) begin
      cnt_d = '0;
    end else if (tick && (cnt_q != CNT_W'(MAX_LIM))) begin
      cnt_d = cnt_inc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/usb_spd_fsm.sv
module usb_spd_fsm
  import usb_spd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ls_only,
  input  pid_cls_e cls,
  input  logic     pkt_end,
  input  logic     expire,
  output logic     ls_active,
  output logic     timer_run,
  output logic     in_win
);

  spd_state_e st_q;
  spd_state_e st_d;
  logic       st_en;

  always_comb begin
    st_d = st_q;
    if (ls_only) begin
      st_d = ST_FS_IDLE;
    end else begin
      unique case (st_q)
        ST_FS_IDLE: begin
          if (cls == PC_PRE) st_d = ST_LS_TOKEN;
        end
        ST_LS_TOKEN: begin
          if (cls == PC_TOK_SO)      st_d = ST_LS_TOK_END;
          else if (cls == PC_TOK_IN) st_d = ST_LS_IN_WAIT;
          else if (cls != PC_NONE)   st_d = ST_FS_IDLE;
          else if (expire)           st_d = ST_FS_IDLE;
        end
        ST_LS_TOK_END: begin
          if (cls != PC_NONE) st_d = ST_FS_IDLE;
          else if (pkt_end)   st_d = ST_FS_DATA_PRE;
        end
        ST_FS_DATA_PRE: begin
          if (cls == PC_PRE)       st_d = ST_LS_DATA;
          else if (cls != PC_NONE) st_d = ST_FS_IDLE;
        end
        ST_LS_DATA: begin
          if (cls == PC_DATA || cls == PC_HSK) st_d = ST_LS_DATA_END;
          else if (cls != PC_NONE)             st_d = ST_FS_IDLE;
          else if (expire)                     st_d = ST_FS_IDLE;
        end
        ST_LS_IN_WAIT: begin
          if (cls == PC_DATA)      st_d = ST_LS_IN_END;
          else if (cls != PC_NONE) st_d = ST_FS_IDLE;
          else if (expire)         st_d = ST_FS_IDLE;
        end
        ST_LS_DATA_END, ST_LS_IN_END: begin
          if (cls != PC_NONE || pkt_end) st_d = ST_FS_IDLE;
        end
        default: st_d = ST_FS_IDLE;
      endcase
    end
    st_en = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_FS_IDLE;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  always_comb begin
    ls_active = !(st_q == ST_FS_IDLE || st_q == ST_FS_DATA_PRE);
    timer_run = (st_q == ST_LS_TOKEN) || (st_q == ST_LS_DATA) ||
                (st_q == ST_LS_IN_WAIT);
    in_win    = (st_q == ST_LS_IN_WAIT);
  end

endmodule

// File: rtl/usb_speed_tracker.sv
module usb_speed_tracker
  import usb_spd_pkg::*;
#(
  parameter int GEN_LIMIT = 17,
  parameter int IN_LIMIT  = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pid_valid,
  input  logic [PID_W-1:0] pid,
  input  logic             pkt_end,
  input  logic             ls_tick,
  input  logic             ls_only,
  output logic             ls_sel,
  output logic             ls_detect
);

  pid_cls_e cls;
  logic     expire;
  logic     ls_active;
  logic     timer_run;
  logic     in_win;
  logic     timer_clr;

  usb_spd_pid_class u_cls (
    .pid_valid (pid_valid),
    .pid       (pid),
    .cls       (cls)
  );

  assign timer_clr = pid_valid || pkt_end || ls_only;

  usb_spd_timer #(
    .GEN_LIMIT (GEN_LIMIT),
    .IN_LIMIT  (IN_LIMIT)
  ) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (timer_clr),
    .run    (timer_run),
    .in_win (in_win),
    .tick   (ls_tick),
    .expire (expire)
  );

  usb_spd_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ls_only   (ls_only),
    .cls       (cls),
    .pkt_end   (pkt_end),
    .expire    (expire),
    .ls_active (ls_active),
    .timer_run (timer_run),
    .in_win    (in_win)
  );

  assign ls_sel    = ls_only || ls_active;
  assign ls_detect = ls_sel;

endmodule

// File: rtl/usb_speed_tracker_chk.sv
module usb_speed_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pid_valid,
  input logic [3:0] pid,
  input logic       pkt_end,
  input logic       ls_tick,
  input logic       ls_only,
  input logic       ls_sel
);

  logic at_fs;
  logic at_ls;
  logic is_pre;

  assign at_fs  = !ls_sel && !ls_only;
  assign at_ls  = ls_sel && !ls_only;
  assign is_pre = pid_valid && (pid == 4'hC);

  a_r10_strap_holds_ls: assert property (@(posedge clk) disable iff (!rst_n)
    ls_only |-> ls_sel);

  a_r2_pre_enters_ls: assert property (@(posedge clk) disable iff (!rst_n)
    (at_fs && is_pre) |=> ls_sel);

  a_r2_fs_needs_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (at_fs && !is_pre) |=> (!ls_sel || ls_only));

  a_r8_ls_holds_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (at_ls && !pid_valid && !pkt_end && !ls_tick) |=> ls_sel);

  a_r9_pre_at_ls_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (at_ls && is_pre) |=> (!ls_sel || ls_only));

endmodule

bind usb_speed_tracker usb_speed_tracker_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pid_valid (pid_valid),
  .pid       (pid),
  .pkt_end   (pkt_end),
  .ls_tick   (ls_tick),
  .ls_only   (ls_only),
  .ls_sel    (ls_sel)
);

// File: tb/tb_usb_speed_tracker.sv
module tb_usb_speed_tracker;

  logic       clk;
  logic       rst_n;
  logic       pid_valid;
  logic [3:0] pid;
  logic       pkt_end;
  logic       ls_tick;
  logic       ls_only;
  logic       ls_sel;
  logic       ls_detect;

  int checks;
  int failures;
  bit done;

  usb_speed_tracker dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pid_valid (pid_valid),
    .pid       (pid),
    .pkt_end   (pkt_end),
    .ls_tick   (ls_tick),
    .ls_only   (ls_only),
    .ls_sel    (ls_sel),
    .ls_detect (ls_detect)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- behavioural reference ----------------
  // phase names: "idle","tok","tokend","pre2","dat","datend","inw","inend"
  string phase;
  int    quiet;

  function automatic bit phase_is_ls(string p);
    return !(p == "idle" || p == "pre2");
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = "idle";
      quiet = 0;
    end else if (ls_only) begin
      phase = "idle";
      quiet = 0;
    end else begin
      string  nxt;
      bit     waiting;
      int     lim;
      bit     tmo;
      nxt     = phase;
      waiting = (phase == "tok" || phase == "dat" || phase == "inw");
      lim     = (phase == "inw") ? 18 : 17;
      tmo     = 1'b0;
      if (pid_valid || pkt_end || !waiting) quiet = 0;
      else if (ls_tick) begin
        quiet++;
        if (quiet >= lim) tmo = 1'b1;
      end
      if (pid_valid) begin
        case (phase)
          "idle":  nxt = (pid == 4'hC) ? "tok" : "idle";
          "tok":   nxt = (pid == 4'hD || pid == 4'h1) ? "tokend" :
                         (pid == 4'h9) ? "inw" : "idle";
          "pre2":  nxt = (pid == 4'hC) ? "dat" : "idle";
          "dat":   nxt = (pid inside {4'h3, 4'hB, 4'h2, 4'hA, 4'hE}) ? "datend" : "idle";
          "inw":   nxt = (pid inside {4'h3, 4'hB}) ? "inend" : "idle";
          default: nxt = "idle";
        endcase
      end else if (pkt_end) begin
        if (phase == "tokend") nxt = "pre2";
        else if (phase == "datend" || phase == "inend") nxt = "idle";
      end else if (tmo) begin
        nxt = "idle";
      end
      if (nxt != phase) quiet = 0;
      phase = nxt;
    end
  end

  // every-cycle comparison, away from the active edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic exp_sel;
      exp_sel = ls_only || phase_is_ls(phase);
      checks++;
      if (ls_sel !== exp_sel || ls_detect !== exp_sel) begin
        failures++;
        $display("FAIL R1 model phase=%s act sel=%0b det=%0b exp=%0b",
                 phase, ls_sel, ls_detect, exp_sel);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic send_pid(logic [3:0] p);
    @(negedge clk);
    pid_valid = 1'b1;
    pid       = p;
    @(negedge clk);
    pid_valid = 1'b0;
  endtask

  task automatic send_end();
    @(negedge clk);
    pkt_end = 1'b1;
    @(negedge clk);
    pkt_end = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ls_tick = 1'b1;
      @(negedge clk);
      ls_tick = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; pid_valid = 1'b0; pid = 4'h0;
    pkt_end = 1'b0; ls_tick = 1'b0; ls_only = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset sel", ls_sel, 1'b0);
    chk("R1 reset det", ls_detect, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // SETUP with data phase
    send_pid(4'hC); chk("R2 pre", ls_sel, 1'b1);
    send_pid(4'hD); chk("R3 setup held", ls_sel, 1'b1);
    ticks(10);      chk("R3 token in flight", ls_sel, 1'b1);
    send_end();     chk("R3 token end", ls_sel, 1'b0);
    send_pid(4'hC); chk("R4 second pre", ls_sel, 1'b1);
    send_pid(4'h3); chk("R4 data0 held", ls_sel, 1'b1);
    send_end();     chk("R4 data end", ls_sel, 1'b0);

    // OUT then handshake in data window
    send_pid(4'hC); send_pid(4'h1); send_end();
    chk("R3 out end", ls_sel, 1'b0);
    send_pid(4'hC); send_pid(4'h2); chk("R4 ack held", ls_sel, 1'b1);
    send_end();     chk("R4 ack end", ls_sel, 1'b0);

    // IN timeout window
    send_pid(4'hC); send_pid(4'h9);
    ticks(17);      chk("R6 17 ticks", ls_sel, 1'b1);
    ticks(1);       chk("R6 18th tick", ls_sel, 1'b0);

    // IN with device data
    send_pid(4'hC); send_pid(4'h9); ticks(5);
    send_pid(4'hB); ticks(30); chk("R5 data1 in flight", ls_sel, 1'b1);
    send_end();     chk("R5 data end", ls_sel, 1'b0);

    // general timeout, token window
    send_pid(4'hC); ticks(16); chk("R7 16 ticks", ls_sel, 1'b1);
    ticks(1);       chk("R7 17th tick", ls_sel, 1'b0);

    // general timeout, data window
    send_pid(4'hC); send_pid(4'hD); send_end(); send_pid(4'hC);
    ticks(16);      chk("R7 data win 16", ls_sel, 1'b1);
    ticks(1);       chk("R7 data win 17", ls_sel, 1'b0);

    // restart and gating of the count
    ticks(40);      chk("R8 fs ticks", ls_sel, 1'b0);
    send_pid(4'hC); ticks(16); send_end(); ticks(16);
    chk("R8 restart by end", ls_sel, 1'b1);
    ticks(1);       chk("R8 after restart", ls_sel, 1'b0);

    // mismatches
    send_pid(4'hC); send_pid(4'h3); chk("R9 data as token", ls_sel, 1'b0);
    send_pid(4'hC); send_pid(4'hD); send_pid(4'hA);
    chk("R9 pid during token", ls_sel, 1'b0);
    send_pid(4'hC); send_pid(4'h9); send_pid(4'h2);
    chk("R9 ack after in", ls_sel, 1'b0);

    // cancel while waiting for the second preamble
    send_pid(4'hC); send_pid(4'hD); send_end();
    send_pid(4'h5); chk("R11 sof at fs", ls_sel, 1'b0);
    send_pid(4'hC); chk("R11 new pre", ls_sel, 1'b1);
    send_pid(4'h3); chk("R11 first window rejects data", ls_sel, 1'b0);

    // low-speed-only strap
    @(negedge clk); ls_only = 1'b1;
    @(negedge clk); chk("R10 strap", ls_sel, 1'b1);
    send_pid(4'hC); send_pid(4'h3); send_end(); ticks(40);
    chk("R10 strap ignores traffic", ls_sel, 1'b1);
    chk("R10 strap detect", ls_detect, 1'b1);
    @(negedge clk); ls_only = 1'b0;
    @(negedge clk); chk("R10 release", ls_sel, 1'b0);
    send_pid(4'h3); chk("R10 idle after release", ls_sel, 1'b0);
    send_pid(4'hC); send_pid(4'h9);
    chk("R10 fresh first window", ls_sel, 1'b1);
    send_pid(4'h3); send_end();
    chk("R5 in after release", ls_sel, 1'b0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule